// File: doc/BRIEF.md
# Burst Column Sequencer

This block turns the starting column of a DRAM read or write into the column offset of every beat of the burst. It runs on the beat-rate clock, so each cycle is one beat slot. A start strobe carries the starting column, a three-bit burst-length code and a one-bit ordering select. These values are captured when the start is accepted. The block then steps through four or eight beats. For each beat it presents the column together with a valid flag, and it raises a done flag on the final beat.

The ordering follows the usual DRAM rules:
- Interleaved ordering XORs the beat index into the low column bits.
- Sequential ordering adds the beat index modulo four.
- In an eight-beat sequential burst, bit 2 flips halfway through, so the burst visits the starting nibble first and then the other nibble.

Column bits above the aligned segment never change. A burst cannot be stopped or cut short. A new start is taken only when the sequencer is idle or on the last beat of a burst. A start on the last beat gives back-to-back bursts with no idle slot between them.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and after it is released, with no start given, beat_valid and burst_done are 0.
- R2: bl_code 3'b010 selects a 4-beat burst and 3'b011 an 8-beat burst. A start with any other code is ignored: beat_valid stays 0 in the next cycle. bl_code, order_sel and start_col are sampled only at an accepted start, and changing them during a burst has no effect on it.
- R3: One cycle after an accepted start, beat_valid is 1 and beat_col equals the starting column.
- R4: 4-beat sequential (order_sel = 0): beat i has bits [1:0] = (start[1:0] + i) mod 4. All higher bits equal the start column.
- R5: 4-beat interleaved (order_sel = 1): beat i has bits [1:0] = start[1:0] XOR i. All higher bits equal the start column.
- R6: 8-beat sequential: beat i has bits [1:0] = (start[1:0] + i) mod 4 and bit 2 = start[2] XOR i[2]. All higher bits equal the start column.
- R7: 8-beat interleaved: beat i has bits [2:0] = start[2:0] XOR i. All higher bits equal the start column.
- R8: Column bits from bit 3 upward stay constant through every beat of a burst.
- R9: burst_done is 1 on the last beat of each burst and only there, and only together with beat_valid.
- R10: A start that arrives while a burst is running and not on its last beat is ignored. The running burst completes unchanged and no extra beats follow it.
- R11: A legal start given on the last beat of a burst makes beat 0 of the new burst appear in the very next cycle.
- R12: Each accepted burst produces exactly 4 or 8 consecutive valid beats, with no gap inside the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a burst |
| start_col | input | COL_W | Starting column address |
| bl_code | input | 3 | Burst-length code (3'b010 = 4 beats, 3'b011 = 8 beats) |
| order_sel | input | 1 | 0 = sequential, 1 = interleaved |
| beat_col | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| burst_done | output | 1 | The current beat is the last of its burst |

## Verification
Every output comes straight from registers. A start sampled at one rising edge therefore shows beat 0 one cycle later, and beat i appears i cycles after that. The driver changes inputs at the falling edge. Only after the sampling rising edge does it queue the expected beats, so they are already in the queue when the monitor compares the outputs at the next falling edge. Ignored starts queue nothing. A beat that appears with an empty queue is reported as a failure, and so is a missing beat while the queue still holds items. This covers rejected codes, starts that arrive mid-burst and back-to-back bursts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;

  localparam logic [2:0] CODE_LEN4 = 3'b010;
  localparam logic [2:0] CODE_LEN8 = 3'b011;
  localparam int         BEAT_IDX_W = 3;

  // Low three column bits for beat idx of a burst that began at low3.
  function automatic logic [2:0] beat_low_bits(
    input logic [2:0] low3,
    input logic [2:0] idx,
    input order_e     ord,
    input logic       len8
  );
    logic [1:0] wrap2;
    logic       nib;
    if (ord == ORD_INTLV) wrap2 = low3[1:0] ^ idx[1:0];
    else                  wrap2 = low3[1:0] + idx[1:0];
    nib = low3[2] ^ (len8 & idx[2]);
    return {nib, wrap2};
  endfunction

endpackage

// File: rtl/bseq_mode_decode.sv
module bseq_mode_decode
  import burst_seq_pkg::*;
(
  input  logic [2:0] bl_code,
  output logic       code_legal,
  output logic       code_len8
);
  always_comb begin
    code_legal = (bl_code == CODE_LEN4) || (bl_code == CODE_LEN8);
    code_len8  = (bl_code == CODE_LEN8);
  end
endmodule

// File: rtl/bseq_beat_ctrl.sv
module bseq_beat_ctrl
  import burst_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  load_len8,
  output logic                  busy,
  output logic                  len8,
  output logic [BEAT_IDX_W-1:0] idx,
  output logic                  last
);
  logic [BEAT_IDX_W-1:0] final_idx;

  always_comb begin
    final_idx = len8 ? 3'd7 : 3'd3;
    last      = busy && (idx == final_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      len8 <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      len8 <= load_len8;
      idx  <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      idx <= BEAT_IDX_W'(idx + 1'b1);
    end
  end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0]      base_col,
  input  logic [BEAT_IDX_W-1:0] idx,
  input  order_e                ord,
  input  logic                  len8,
  output logic [COL_W-1:0]      col
);
  assign col[2:0] = beat_low_bits(base_col[2:0], idx, ord, len8);

  generate
    if (COL_W > 3) begin : g_upper
      assign col[COL_W-1:3] = base_col[COL_W-1:3];
    end
  endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             order_sel,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_valid,
  output logic             burst_done
);
  logic                  mode_legal;
  logic                  mode_len8;
  logic                  busy;
  logic                  len8_q;
  logic                  last_beat;
  logic                  accept;
  logic [BEAT_IDX_W-1:0] beat_idx;
  logic [COL_W-1:0]      base_col;
  order_e                order_q;

  bseq_mode_decode u_dec (
    .bl_code    (bl_code),
    .code_legal (mode_legal),
    .code_len8  (mode_len8)
  );

  assign accept = start && mode_legal && (!busy || last_beat);

  bseq_beat_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .load_len8 (mode_len8),
    .busy      (busy),
    .len8      (len8_q),
    .idx       (beat_idx),
    .last      (last_beat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_col <= '0;
      order_q  <= ORD_SEQ;
    end else if (accept) begin
      base_col <= start_col;
      order_q  <= order_e'(order_sel);
    end
  end

  bseq_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_col (base_col),
    .idx      (beat_idx),
    .ord      (order_q),
    .len8     (len8_q),
    .col      (beat_col)
  );

  assign beat_valid = busy;
  assign burst_done = last_beat;
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_valid,
  input logic             burst_done,
  input logic             accept,
  input logic             mode_legal,
  input logic             busy
);
  a_r3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> beat_valid && beat_col == $past(start_col));

  a_r2_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mode_legal && !busy |=> !beat_valid);

  a_r9_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> beat_valid);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  a_r10_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !burst_done |=> beat_valid && !$past(accept));

  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && $past(beat_valid) && !$past(accept) |-> $stable(beat_col[COL_W-1:3]));

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !beat_valid && !burst_done);
endmodule

bind burst_col_seq bseq_checker #(.COL_W(COL_W)) u_bseq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_col  (start_col),
  .beat_col   (beat_col),
  .beat_valid (beat_valid),
  .burst_done (burst_done),
  .accept     (accept),
  .mode_legal (mode_legal),
  .busy       (busy)
);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = 3'b010;
  logic             order_sel = 1'b0;
  logic [COL_W-1:0] beat_col;
  logic             beat_valid;
  logic             burst_done;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int    col;
    bit    done;
    string tag;
  } beat_t;
  beat_t expq[$];

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .order_sel(order_sel), .beat_col(beat_col),
    .beat_valid(beat_valid), .burst_done(burst_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected column, written from the ordering rules in arithmetic form.
  function automatic int ref_col(int s, int i, int len, bit intlv);
    int grp, lo, hb;
    grp = len;
    if (intlv) return (s - (s % grp)) + ((s % grp) ^ i);
    lo = ((s % 4) + (i % 4)) % 4;
    if (len == 4) return (s - (s % 4)) + lo;
    hb = (((s / 4) % 2) + (i / 4)) % 2;
    return (s - (s % 8)) + hb * 4 + lo;
  endfunction

  // Call just after a falling edge; queues beats once the start is sampled.
  task automatic issue(input int col, input logic [2:0] code, input bit intlv,
                       input int len, input string tag);
    start = 1'b1; start_col = COL_W'(col); bl_code = code; order_sel = intlv;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      beat_t b;
      b.col = ref_col(col, i, len, intlv);
      b.done = (i == len - 1);
      b.tag = tag;
      expq.push_back(b);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (beat_valid || expq.size() != 0);
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (beat_valid) begin
          if (expq.size() == 0) begin
            check(1'b0, "R10/R12 unexpected beat", int'(beat_col), -1);
          end else begin
            beat_t b;
            b = expq.pop_front();
            check(int'(beat_col) == b.col, {b.tag, " column"}, int'(beat_col), b.col);
            check(burst_done == b.done, {"R9 done on ", b.tag}, int'(burst_done), int'(b.done));
          end
        end else if (expq.size() != 0) begin
          check(1'b0, "R12 missing beat", 0, expq[0].col);
          void'(expq.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!beat_valid, "R1 valid in reset", int'(beat_valid), 0);
    check(!burst_done, "R1 done in reset", int'(burst_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!beat_valid && !burst_done, "R1 idle after reset", int'(beat_valid), 0);

    // Orderings
    @(negedge clk); issue('h0D, 3'b010, 1'b0, 4, "R4 R3"); wait_idle();
    @(negedge clk); issue('h2E, 3'b010, 1'b1, 4, "R5"); wait_idle();
    @(negedge clk); issue('h15, 3'b011, 1'b0, 8, "R6 R8"); wait_idle();
    @(negedge clk); issue('h0A, 3'b011, 1'b0, 8, "R6"); wait_idle();
    @(negedge clk); issue('h3FB, 3'b011, 1'b1, 8, "R7 R8"); wait_idle();
    @(negedge clk); issue('h106, 3'b011, 1'b1, 8, "R7"); wait_idle();

    // Illegal codes ignored
    foreach (expq[k]) ; // queue empty here
    for (int c = 0; c < 8; c++) begin
      if (c != 2 && c != 3) begin
        @(negedge clk); issue('h44, 3'(c), 1'b0, 0, "R2");
        @(negedge clk);
        check(!beat_valid, "R2 illegal code ignored", int'(beat_valid), 0);
      end
    end

    // Mode inputs changed mid-burst have no effect
    @(negedge clk); issue('h103, 3'b011, 1'b1, 8, "R2 held mode");
    @(negedge clk); bl_code = 3'b010; order_sel = 1'b0; start_col = '0;
    wait_idle();

    // Start mid-burst is ignored
    @(negedge clk); issue('h22, 3'b010, 1'b0, 4, "R10");
    @(negedge clk); start = 1'b1; start_col = 'h55; bl_code = 3'b011;
    @(posedge clk); #1 start = 1'b0;
    wait_idle();
    @(negedge clk); issue('h39, 3'b011, 1'b0, 8, "R10");
    repeat (3) @(negedge clk);
    start = 1'b1; start_col = 'h77; bl_code = 3'b010;
    @(posedge clk); #1 start = 1'b0;
    wait_idle();

    // Back-to-back on the last beat
    @(negedge clk); issue('h31, 3'b010, 1'b1, 4, "R11");
    do @(negedge clk); while (!burst_done);
    issue('h1C, 3'b011, 1'b0, 8, "R11");
    do @(negedge clk); while (!burst_done);
    issue('h2B, 3'b010, 1'b0, 4, "R11");
    wait_idle();

    repeat (2) @(negedge clk);
    check(expq.size() == 0, "R12 leftover beats", expq.size(), 0);
    check(!beat_valid, "R12 idle at end", int'(beat_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule